// File: doc/BRIEF.md
# Windowed Watchdog with Keyed Service Byte

This block is a watchdog that measures elapsed time in strobes of a slow timer tick, not in system clock cycles. Software services it by writing one byte to a service register. A service is accepted only inside a window. It is an error if it comes before a fixed minimum number of ticks has passed since the last service. It is also an error if no service arrives before a selectable maximum. Every error shows up as a single-cycle pulse on the error output.

The service byte has three parts: a two-bit upper-window select, a five-bit constant key and a monitor-enable bit. After reset the block is armed with the longest window and the monitor enable set. The first write that carries the right key fixes the window and the enable until the next reset. Every write after that must repeat the stored byte exactly. A boot-entry strobe services the watchdog at once and never raises the early-service error.

Top module: `wdt_keyed_window`

## Requirements
- R1: The tick counter advances only in cycles where `tick` is high. System clock cycles without a tick do not bring either window limit closer.
- R2: While `rst_n` is low, and in the first cycle after it is released, the outputs are `wd_err`=0, `win_sel`=2'b11 and `cm_en`=1, and the configuration is unlocked.
- R3: The upper limit is UPPER_BASE shifted left by `win_sel` ticks: 00 gives 1x, 01 gives 2x, 10 gives 4x and 11 gives 8x, where the default UPPER_BASE of 8192 ticks gives 8k to 64k. Without a service, `wd_err` pulses in the cycle after the tick that completes the limit.
- R4: A write after the configuration is locked is an error when fewer than LOWER_TICKS ticks (default 2048) have passed since the last restart.
- R5: The key occupies bits 5:1 of the service byte and must equal 5'b01100. A first write with a different key raises `wd_err` and leaves the configuration unlocked.
- R6: The first write with the correct key loads bits 7:6 into `win_sel` and bit 0 into `cm_en`, then locks them. This write restarts the counter and is not subject to the lower-limit check.
- R7: Once the configuration is locked, a write must equal the stored byte {win_sel, 5'b01100, cm_en} in all 8 bits. Any mismatch raises `wd_err` and leaves `win_sel` and `cm_en` unchanged.
- R8: A `boot_enter` strobe restarts the counter and never produces `wd_err`, even when it comes early. A `svc_wr` in the same cycle is ignored.
- R9: Every service and every error clears the counter to zero, including when a tick arrives in the same cycle. `wd_err` is registered and stays high for one cycle per violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe from the slow timer |
| svc_wr | input | 1 | Write strobe for the service register |
| svc_data | input | 8 | Byte written to the service register |
| boot_enter | input | 1 | Boot-entry strobe that forces an immediate service |
| wd_err | output | 1 | One-cycle pulse on each watchdog violation |
| cm_en | output | 1 | Stored clock-monitor enable |
| win_sel | output | 2 | Stored upper-window select |

## Verification
Each result is produced by a single register stage. A violating write, a bad key or the tick that completes the upper limit shows on `wd_err` in the cycle right after the input was sampled. A locking write updates `win_sel` and `cm_en` on the same edge. The bench drives every stimulus at a falling edge and samples one time unit after the next rising edge, so each check reads exactly the cycle its result is due. Window boundaries are tested one tick short and exactly on the limit, and each restart is confirmed by counting a full upper window afterwards.

// File: rtl/wdt_kw_pkg.sv
// Shared constants and types for the keyed windowed watchdog.
// Assumes: the service byte layout is {window[1:0], key[4:0], monitor_en}.
package wdt_kw_pkg;
    localparam logic [4:0] SVC_KEY = 5'b01100;

    typedef struct packed {
        logic [1:0] win;
        logic       cm;
    } wdt_cfg_t;

    localparam wdt_cfg_t CFG_RST = '{win: 2'b11, cm: 1'b1};
endpackage

// File: rtl/wdt_cfg_lock.sv
// Write-once configuration store for the watchdog.
// Holds the window select and the monitor enable. It loads them from the first
// accepted write whose key field matches, then locks them until reset.
// Assumes: wr_take is already qualified, so it is never high in a boot-entry cycle.
module wdt_cfg_lock
    import wdt_kw_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_take,
    input  logic [7:0]     wr_byte,
    output logic           locked,
    output logic           key_ok,
    output logic           byte_match,
    output wdt_cfg_t       cfg
);
    // Compare the key field and the full byte against the stored configuration.
    always_comb begin
        key_ok     = (wr_byte[5:1] == SVC_KEY);
        byte_match = (wr_byte == {cfg.win, SVC_KEY, cfg.cm});
    end

    // Load the configuration once, on the first write with a matching key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg    <= CFG_RST;
            locked <= 1'b0;
        end else if (wr_take && !locked && key_ok) begin
            cfg    <= '{win: wr_byte[7:6], cm: wr_byte[0]};
            locked <= 1'b1;
        end
    end

    // R6
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(cfg)));
endmodule

// File: rtl/wdt_tick_cnt.sv
// Tick counter with lower and upper window comparison.
// It counts tick strobes since the last restart. It reports "early" while the
// count is below the lower limit, and "expire" on the tick that completes the
// upper limit chosen by win.
// Assumes: clear and expire both return the count to zero on the next edge.
module wdt_tick_cnt #(
    parameter int LOWER_TICKS = 2048,
    parameter int UPPER_BASE  = 8192,
    localparam int CW = $clog2(UPPER_BASE * 8)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clear,
    input  logic [1:0]    win,
    output logic [CW-1:0] cnt,
    output logic          early,
    output logic          expire
);
    logic [CW:0] limit;

    // Derive the upper limit from the window select and compare the count with both limits.
    always_comb begin
        limit  = (CW+1)'(UPPER_BASE) << win;
        early  = ({1'b0, cnt} < (CW+1)'(LOWER_TICKS));
        expire = tick && ({1'b0, cnt} == limit - 1'b1);
    end

    // Advance on each tick. Return to zero on a restart or an expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (clear || expire) cnt <= '0;
        else if (tick)            cnt <= cnt + 1'b1;
    end

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt));
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt} < limit));
endmodule

// File: rtl/wdt_keyed_window.sv
// Top level of the keyed windowed watchdog.
// It decides for each cycle whether the inputs are a boot service, a first
// (configuring) write, a later service write or a timeout. It registers one
// error pulse for every violation.
// Assumes: tick, svc_wr and boot_enter are single-cycle strobes synchronous to clk.
module wdt_keyed_window
    import wdt_kw_pkg::*;
#(
    parameter int LOWER_TICKS = 2048,
    parameter int UPPER_BASE  = 8192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    input  logic       boot_enter,
    output logic       wd_err,
    output logic       cm_en,
    output logic [1:0] win_sel
);
    localparam int CW = $clog2(UPPER_BASE * 8);

    wdt_cfg_t      cfg;
    logic          locked, key_ok, byte_match;
    logic          wr_take, restart, early, expire, err_d;
    logic [CW-1:0] cnt;

    // Decide which event this cycle carries. Boot entry wins over a write.
    always_comb begin
        wr_take = svc_wr && !boot_enter;
        restart = boot_enter || wr_take;
        err_d   = (wr_take && !locked && !key_ok)
                || (wr_take && locked && (!byte_match || early))
                || (expire && !restart);
    end

    wdt_cfg_lock u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_take    (wr_take),
        .wr_byte    (svc_data),
        .locked     (locked),
        .key_ok     (key_ok),
        .byte_match (byte_match),
        .cfg        (cfg)
    );

    wdt_tick_cnt #(
        .LOWER_TICKS (LOWER_TICKS),
        .UPPER_BASE  (UPPER_BASE)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clear  (restart),
        .win    (cfg.win),
        .cnt    (cnt),
        .early  (early),
        .expire (expire)
    );

    // Register the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) wd_err <= 1'b0;
        else        wd_err <= err_d;
    end

    assign cm_en   = cfg.cm;
    assign win_sel = cfg.win;

    // R2
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (win_sel == 2'b11 && cm_en && !wd_err));
    // R9
    err_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_err |-> (cnt == '0));
    // R8
    boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_enter |=> !wd_err);
    // R4
    early_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && !boot_enter && locked && early) |=> wd_err);
endmodule

// File: tb/tb_wdt_keyed_window.sv
// Directed bench for the keyed windowed watchdog, with reduced window sizes.
module tb_wdt_keyed_window;
    localparam int LOW  = 16;
    localparam int BASE = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       boot_enter = 1'b0;
    logic       wd_err, cm_en;
    logic [1:0] win_sel;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wdt_keyed_window #(.LOWER_TICKS(LOW), .UPPER_BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .svc_wr(svc_wr),
        .svc_data(svc_data), .boot_enter(boot_enter),
        .wd_err(wd_err), .cm_en(cm_en), .win_sel(win_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge and sample just after the rising edge.
    task automatic step(input logic t, input logic w, input logic [7:0] d, input logic b);
        @(negedge clk);
        tick = t; svc_wr = w; svc_data = d; boot_enter = b;
        @(posedge clk);
        #1;
        tick = 1'b0; svc_wr = 1'b0; boot_enter = 1'b0;
    endtask

    // Apply n ticks and confirm that no error pulse appears.
    task automatic quiet_ticks(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, 8'h00, 1'b0);
            if (wd_err) seen++;
        end
        chk(req, seen, 0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R2 err", wd_err, 0);
        chk("R2 win", win_sel, 3);
        chk("R2 cm", cm_en, 1);
    endtask

    // R1 and R3: idle cycles do not count; default window expires after 8*BASE ticks.
    task automatic t_idle_and_default_limit();
        for (int i = 0; i < 700; i++) step(1'b0, 1'b0, 8'h00, 1'b0);
        quiet_ticks(8*BASE - 1, "R1 no error before limit");
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R3 default limit error", wd_err, 1);
        step(1'b0, 1'b0, 8'h00, 1'b0);
        chk("R9 one-cycle pulse", wd_err, 0);
    endtask

    // R5 then R6: bad key errors and leaves unlocked; valid key then locks at once.
    task automatic t_key();
        step(1'b0, 1'b1, 8'hFF, 1'b0);
        chk("R5 bad key error", wd_err, 1);
        chk("R5 win unchanged", win_sel, 3);
        chk("R5 cm unchanged", cm_en, 1);
        step(1'b0, 1'b1, 8'h18, 1'b0);
        chk("R6 first write no error", wd_err, 0);
        chk("R6 win loaded", win_sel, 0);
        chk("R6 cm loaded", cm_en, 0);
    endtask

    // R4: lower limit boundary.
    task automatic t_early();
        quiet_ticks(LOW - 1, "R4 ticks");
        step(1'b0, 1'b1, 8'h18, 1'b0);
        chk("R4 early service error", wd_err, 1);
        quiet_ticks(LOW, "R4 ticks");
        step(1'b0, 1'b1, 8'h18, 1'b0);
        chk("R4 service at lower limit ok", wd_err, 0);
    endtask

    // R7: later writes must match every stored bit.
    task automatic t_mismatch();
        quiet_ticks(20, "R7 ticks");
        step(1'b0, 1'b1, 8'h19, 1'b0);
        chk("R7 monitor bit mismatch error", wd_err, 1);
        quiet_ticks(20, "R7 ticks");
        step(1'b0, 1'b1, 8'h58, 1'b0);
        chk("R7 window mismatch error", wd_err, 1);
        chk("R7 win kept", win_sel, 0);
        chk("R7 cm kept", cm_en, 0);
    endtask

    // R3 and R9: window 00 boundary, and a service restarting the count.
    task automatic t_upper_min();
        quiet_ticks(BASE - 1, "R3 window 00 quiet");
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R3 window 00 limit error", wd_err, 1);
        quiet_ticks(20, "R9 ticks");
        step(1'b0, 1'b1, 8'h18, 1'b0);
        chk("R9 service ok", wd_err, 0);
        quiet_ticks(BASE - 1, "R9 restart quiet");
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R9 restart measured from service", wd_err, 1);
    endtask

    // R8: boot entry services early without error and overrides a same-cycle write.
    task automatic t_boot();
        quiet_ticks(40, "R8 ticks");
        step(1'b0, 1'b1, 8'h18, 1'b0);
        chk("R8 prior service ok", wd_err, 0);
        quiet_ticks(5, "R8 ticks");
        step(1'b0, 1'b0, 8'h00, 1'b1);
        chk("R8 early boot no error", wd_err, 0);
        quiet_ticks(BASE - 1, "R8 boot restart quiet");
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R8 limit from boot", wd_err, 1);
        step(1'b0, 1'b1, 8'hFF, 1'b1);
        chk("R8 write ignored under boot", wd_err, 0);
        chk("R8 win kept", win_sel, 0);
        quiet_ticks(LOW, "R8 ticks");
        step(1'b0, 1'b1, 8'h18, 1'b0);
        chk("R8 service after boot ok", wd_err, 0);
    endtask

    // R6 and R7 after a fresh reset: config locks once; tick coincident with service (R9).
    task automatic t_relock();
        do_reset();
        chk("R2 win after reset", win_sel, 3);
        step(1'b0, 1'b1, 8'h59, 1'b0);
        chk("R6 win 01 loaded", win_sel, 1);
        chk("R6 cm 1 loaded", cm_en, 1);
        quiet_ticks(20, "R7 ticks");
        step(1'b0, 1'b1, 8'h18, 1'b0);
        chk("R7 relock attempt error", wd_err, 1);
        chk("R7 win stays 01", win_sel, 1);
        quiet_ticks(2*BASE - 1, "R3 window 01 quiet");
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R3 window 01 limit error", wd_err, 1);
        quiet_ticks(20, "R9 ticks");
        step(1'b1, 1'b1, 8'h59, 1'b0);
        chk("R9 service with tick ok", wd_err, 0);
        quiet_ticks(2*BASE - 1, "R9 tick lost on service");
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R9 count cleared despite tick", wd_err, 1);
    endtask

    initial begin
        t_reset();
        t_idle_and_default_limit();
        t_key();
        t_early();
        t_mismatch();
        t_upper_min();
        t_boot();
        t_relock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule